// File: doc/BRIEF.md
# Masked Data Watchpoint Unit

This block watches the data accesses of a core and flags, in the same cycle as the access, every watchpoint channel whose address window covers it. Each channel holds a target address and a control word. The control word carries a six-bit ignore field that widens the window to an aligned block, and two enable bits that select whether loads, stores or both can trigger the channel. Software programs the channels through one shared register write port. The hit vector is combinational, so the core can stop the access before it takes effect.

Each channel runs a two-state machine. In state DISARMED no access can hit. The transition ARM moves it to ARMED when a control write changes the enables or the ignore field and leaves at least one enable set. The transition REARM stays in ARMED and reloads the mask when such a write keeps an enable set. The transition DISARM returns to DISARMED when such a write clears both enables. A control write that changes neither the enables nor the ignore field takes no transition. A non-contiguous ignore field is trimmed into a contiguous one when a channel arms or re-arms. The trim is reported by a one-cycle pulse.

Top module: `dbw_unit`

## Requirements
- R1: After reset every channel is DISARMED, `armed_o` and `mask_fix_o` are zero, and no access raises a hit.
- R2: Control bits [5:0] form the ignore field. An address bit whose ignore bit is set is left out of the comparison. A field of the form 2^k-1 watches the block of 2^k bytes aligned to 2^k that contains the target address. Address bits above bit 5 are always compared.
- R3: If the ignore field is not of the form 2^k-1, the armed field becomes all ones from its highest set bit down to bit 0. `mask_fix_o` for that channel is then high for exactly the one cycle after the write.
- R4: Control bit 30 enables loads and bit 31 enables stores. `acc_store`=1 marks a store and 0 marks a load. An access of a type that is not enabled never hits.
- R5: A control write that clears both bits 30 and 31 moves the channel to DISARMED. `armed_o` then drops, and the channel raises no hit.
- R6: `hit_o` is combinational in the cycle where `acc_valid` is high. It needs no clock edge and is never high without `acc_valid`.
- R7: A control write that changes neither the enables nor the ignore field leaves the armed state unchanged and raises no `mask_fix_o` pulse. This holds even if other control bits differ.
- R8: Register writes take effect at the clock edge that captures them. An access in the same cycle as a write to its channel is judged by the settings that held before that write.
- R9: When several channels match one access, `hit_o` has a bit set for every matching channel. Bit i belongs to channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | CH_W | Channel index of the write |
| wr_is_ctrl | input | 1 | 1 writes the control word, 0 writes the target address |
| wr_data | input | ADDR_W | Write data |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | ADDR_W | Access address |
| hit_o | output | NUM_CH | Per-channel hit, combinational |
| armed_o | output | NUM_CH | Channel is in ARMED |
| mask_fix_o | output | NUM_CH | One-cycle pulse after a trimmed ignore field was armed |

## Verification
The two functions that can fall in the same cycle are a register write to a channel and an access judged by that same channel. The bench provokes this by holding one hitting access while, in that cycle, it first moves the channel's target address away and later disarms the channel. The hit is sampled before the capturing edge and must show the old decision. It is sampled again after the edge, with the access unchanged, and must show the new one. Simultaneous hits on two channels, and the trim pulse next to writes that take no transition, are judged in the same way, cycle by cycle.

// File: rtl/dbw_pkg.sv
`timescale 1ns/1ps
package dbw_pkg;
    typedef enum logic {
        CH_DISARMED = 1'b0,
        CH_ARMED    = 1'b1
    } ch_state_e;
endpackage

// File: rtl/dbw_mask_trim.sv
`timescale 1ns/1ps
// Makes an ignore field contiguous: every bit at or below the highest set bit becomes one.
module dbw_mask_trim #(
    parameter int W = 6
) (
    input  logic [W-1:0] field_i,
    output logic [W-1:0] trimmed_o,
    output logic         cut_o
);
    always_comb begin
        for (int i = 0; i < W; i++) begin
            trimmed_o[i] = |(field_i >> i);
        end
        cut_o = (trimmed_o != field_i);
    end
endmodule

// File: rtl/dbw_channel.sv
`timescale 1ns/1ps
module dbw_channel
    import dbw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 6,
    parameter int LD_BIT  = 30,
    parameter int ST_BIT  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_ctrl,
    input  logic              sel_addr,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              hit,
    output logic              armed,
    output logic              mask_fix
);
    localparam int HI_W = ADDR_W - FIELD_W;

    ch_state_e          st_q, st_d;
    logic [ADDR_W-1:0]  tgt_q;
    logic [FIELD_W-1:0] raw_field_q, cut_field_q;
    logic               raw_ld_q, raw_st_q, en_ld_q, en_st_q, fix_q;

    logic [FIELD_W-1:0] new_field, trimmed;
    logic               new_ld, new_st, trimmed_cut, changed, any_en;
    logic [ADDR_W-1:0]  care;
    logic               match, type_ok;

    assign new_field = wr_data[FIELD_W-1:0];
    assign new_ld    = wr_data[LD_BIT];
    assign new_st    = wr_data[ST_BIT];
    assign any_en    = new_ld | new_st;
    assign changed   = sel_ctrl && ((new_field != raw_field_q) ||
                                    (new_ld != raw_ld_q) || (new_st != raw_st_q));

    dbw_mask_trim #(.W(FIELD_W)) trim_i (
        .field_i   (new_field),
        .trimmed_o (trimmed),
        .cut_o     (trimmed_cut)
    );

    // next-state: ARM, REARM, DISARM
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_DISARMED: if (changed && any_en)  st_d = CH_ARMED;
            CH_ARMED:    if (changed && !any_en) st_d = CH_DISARMED;
            default:     st_d = CH_DISARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_DISARMED;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q       <= '0;
            raw_field_q <= '0;
            raw_ld_q    <= 1'b0;
            raw_st_q    <= 1'b0;
            cut_field_q <= '0;
            en_ld_q     <= 1'b0;
            en_st_q     <= 1'b0;
            fix_q       <= 1'b0;
        end else begin
            fix_q <= changed && any_en && trimmed_cut;
            if (sel_addr) tgt_q <= wr_data;
            if (sel_ctrl) begin
                raw_field_q <= new_field;
                raw_ld_q    <= new_ld;
                raw_st_q    <= new_st;
            end
            if (changed) begin
                cut_field_q <= trimmed;
                en_ld_q     <= new_ld;
                en_st_q     <= new_st;
            end
        end
    end

    // outputs
    always_comb begin
        care    = ~{{HI_W{1'b0}}, cut_field_q};
        match   = ((acc_addr ^ tgt_q) & care) == '0;
        type_ok = acc_store ? en_st_q : en_ld_q;
        hit     = acc_valid && (st_q == CH_ARMED) && type_ok && match;
        armed   = (st_q == CH_ARMED);
        mask_fix = fix_q;
    end

    p_disarmed_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_DISARMED) |-> !hit);
    p_armed_field_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_ARMED) |-> ((cut_field_q & (cut_field_q + 1'b1)) == '0));
    p_fix_after_ctrl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_fix |-> $past(sel_ctrl));
    p_arm_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(sel_ctrl));
    p_target_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel_addr) |-> $stable(tgt_q));
endmodule

// File: rtl/dbw_unit.sv
`timescale 1ns/1ps
module dbw_unit #(
    parameter int NUM_CH  = 2,
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 6,
    parameter int LD_BIT  = 30,
    parameter int ST_BIT  = 31,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic              wr_is_ctrl,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [NUM_CH-1:0] hit_o,
    output logic [NUM_CH-1:0] armed_o,
    output logic [NUM_CH-1:0] mask_fix_o
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_c, sel_a;
        assign sel_c = wr_en && wr_is_ctrl  && (wr_chan == CH_W'(i));
        assign sel_a = wr_en && !wr_is_ctrl && (wr_chan == CH_W'(i));

        dbw_channel #(
            .ADDR_W (ADDR_W), .FIELD_W(FIELD_W),
            .LD_BIT (LD_BIT), .ST_BIT (ST_BIT)
        ) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_ctrl  (sel_c),
            .sel_addr  (sel_a),
            .wr_data   (wr_data),
            .acc_valid (acc_valid),
            .acc_store (acc_store),
            .acc_addr  (acc_addr),
            .hit       (hit_o[i]),
            .armed     (armed_o[i]),
            .mask_fix  (mask_fix_o[i])
        );
    end

    p_hit_needs_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o != '0) |-> acc_valid);
endmodule

// File: tb/dbw_unit_tb.sv
`timescale 1ns/1ps
module dbw_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_chan = '0;
    logic        wr_is_ctrl = 1'b0;
    logic [31:0] wr_data = '0;
    logic        acc_valid = 1'b0;
    logic        acc_store = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  hit_o, armed_o, mask_fix_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dbw_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_is_ctrl(wr_is_ctrl), .wr_data(wr_data), .acc_valid(acc_valid),
        .acc_store(acc_store), .acc_addr(acc_addr), .hit_o(hit_o),
        .armed_o(armed_o), .mask_fix_o(mask_fix_o)
    );

    // {store, expected hit[1:0], address}
    localparam logic [34:0] VEC [8] = '{
        {1'b0, 2'b01, 32'h1000_0040},
        {1'b0, 2'b01, 32'h1000_004F},
        {1'b0, 2'b00, 32'h1000_0050},
        {1'b1, 2'b11, 32'h1000_004A},
        {1'b0, 2'b01, 32'h1000_004A},
        {1'b1, 2'b00, 32'h1000_003F},
        {1'b1, 2'b01, 32'h1000_0047},
        {1'b1, 2'b00, 32'h2000_0048}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic ch, input logic ctrl, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = ch; wr_is_ctrl = ctrl; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic probe(input logic st, input logic [31:0] a);
        @(negedge clk);
        acc_valid = 1'b1; acc_store = st; acc_addr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 armed after reset", 32'(armed_o), 32'h0);
        chk("R1 fix after reset", 32'(mask_fix_o), 32'h0);
        probe(1'b0, 32'h0);
        chk("R1 no hit after reset", 32'(hit_o), 32'h0);
        acc_valid = 1'b0;

        wr(1'b0, 1'b0, 32'h1000_0040);
        wr(1'b0, 1'b1, 32'hC000_000F);
        wr(1'b1, 1'b0, 32'h1000_0048);
        wr(1'b1, 1'b1, 32'h8000_0007);
        chk("R2 no fix for contiguous field", 32'(mask_fix_o), 32'h0);
        chk("R4 both armed", 32'(armed_o), 32'h3);

        for (int k = 0; k < 8; k++) begin
            probe(VEC[k][34], VEC[k][31:0]);
            chk($sformatf("R2/R4/R9 table row %0d", k), 32'(hit_o), 32'(VEC[k][33:32]));
        end
        acc_valid = 1'b0;
        #1;
        chk("R6 no hit without access", 32'(hit_o), 32'h0);

        // R3: field 0b000101 trims to 0b000111, loads only
        wr(1'b0, 1'b1, 32'h4000_0005);
        chk("R3 fix pulse", 32'(mask_fix_o), 32'h1);
        @(negedge clk); #1;
        chk("R3 fix one cycle", 32'(mask_fix_o), 32'h0);
        probe(1'b0, 32'h1000_0047);
        chk("R3 trimmed window in", 32'(hit_o), 32'h1);
        probe(1'b0, 32'h1000_0048);
        chk("R3 trimmed window out", 32'(hit_o), 32'h0);
        probe(1'b1, 32'h1000_0047);
        chk("R4 store on load-only", 32'(hit_o), 32'h0);
        acc_valid = 1'b0;

        // R7: no change of enables or field
        wr(1'b0, 1'b1, 32'h4000_0005);
        chk("R7 same word no fix", 32'(mask_fix_o), 32'h0);
        wr(1'b0, 1'b1, 32'h4000_0405);
        chk("R7 other bits no fix", 32'(mask_fix_o), 32'h0);
        probe(1'b0, 32'h1000_0047);
        chk("R7 behaviour kept", 32'(hit_o), 32'h1);

        // R8: address write in the same cycle as a hitting access
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 1'b0; wr_is_ctrl = 1'b0; wr_data = 32'h2000_0000;
        #1;
        chk("R8 old address before edge", 32'(hit_o), 32'h1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R8 new address after edge", 32'(hit_o), 32'h0);
        probe(1'b0, 32'h2000_0003);
        chk("R8 new address hits", 32'(hit_o), 32'h1);

        // R8/R5: disarm in the same cycle as a hitting access
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 1'b0; wr_is_ctrl = 1'b1; wr_data = 32'h0;
        #1;
        chk("R8 old control before edge", 32'(hit_o), 32'h1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R5 disarmed no hit", 32'(hit_o), 32'h0);
        chk("R5 armed drops", 32'(armed_o), 32'h2);
        acc_valid = 1'b0;

        wr(1'b1, 1'b1, 32'h0000_0007);
        chk("R5 all disarmed", 32'(armed_o), 32'h0);
        probe(1'b1, 32'h1000_004A);
        chk("R5 ch1 no hit", 32'(hit_o), 32'h0);
        acc_valid = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule